// File: doc/BRIEF.md
# Serial Flash Status Register Front End

This block is the command front end that a serial NOR flash uses to expose its status register. A host drives chip select, serial clock and serial data in SPI mode 0: data is taken on the rising serial clock edge and changed on the falling edge, most significant bit first. The block oversamples all serial pins with the system clock, so the serial clock must run well below the system clock. It decodes three one-byte opcodes: set the write-enable latch (06h), write the status register (01h) and read the status register (05h). Every other opcode is ignored until chip select is released.

A status write starts a self-timed busy phase whose length, `TW_CYCLES`, is counted in system clocks. The host polls for the end of this phase by reading status, which is allowed at any time. Writes are refused when the write-enable latch is clear, while the busy phase runs, and in hardware protected mode. That mode holds when the protect bit is set and the write-protect pin is low.

Status byte layout: bit 7 = protect bit, bits 6 and 5 = always 0, bits 4..2 = block protect field, bit 1 = write-enable latch, bit 0 = write in progress.

Top module: `flash_status_front`

## Requirements
- R1: After reset the status byte reads 00h and miso is 0.
- R2: After the opcode 05h has been clocked in, each falling serial clock edge presents the next status bit on miso, starting with bit 7, in the layout above.
- R3: While chip select stays low after 05h, the status byte repeats with no gap. Each byte is sampled once, at its first output bit, so its bits all belong to the same instant.
- R4: Opcode 06h sets the write-enable latch (bit 1) only if chip select rises after exactly 8 bits. With any other count the latch is left unchanged.
- R5: Opcode 01h has no effect while the write-enable latch is 0.
- R6: Opcode 01h is carried out only if chip select rises after exactly 16 or exactly 24 bits in total. With any other count nothing changes and the write-enable latch stays set.
- R7: A status write loads bit 7 and bits 4..2 from the first data byte. Bits 6, 5, 1 and 0 of that byte have no effect, a second data byte is ignored, and bits 6 and 5 always read 0.
- R8: An accepted status write sets write-in-progress for exactly `TW_CYCLES` system clocks, and the new bits are visible at once. When the phase ends, write-in-progress and write-enable both drop to 0 in the same cycle.
- R9: While write-in-progress is 1, opcodes 01h and 06h have no effect, but 05h still reads status.
- R10: When bit 7 is 1 and wpN is low, a status write changes no status bit, including the write-enable latch. With wpN high, or with bit 7 clear, the write is carried out.
- R11: Opcodes other than 05h never drive miso high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, mode 0 |
| mosi | input | 1 | Serial data from the host |
| wpN | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to the host, 0 when not reading |

## Verification
Two functions can land in the same system clock: the busy timer expiring, which clears write-in-progress and the write-enable latch together, and the read path taking the snapshot for the next output byte. The bench holds the serial clock high after the read opcode. It then releases it exactly `TW_CYCLES` and `TW_CYCLES`+1 clocks after chip select rose to commit a write. The first case must return a byte with both bits still set, followed by a cleared byte. The second must return the cleared byte at once. Write-in-progress and write-enable must never be seen split within one byte.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam logic [7:0] OP_READ_STATUS  = 8'h05;
  localparam logic [7:0] OP_WRITE_STATUS = 8'h01;
  localparam logic [7:0] OP_WRITE_ENABLE = 8'h06;
  localparam int         BYTE_BITS       = 8;
  localparam int         FRAME_CNT_W     = 5;

  typedef struct packed {
    logic       setWel;
    logic       commitWr;
    logic       shiftOut;
    logic       outIdle;
    logic [7:0] wrByte;
  } fsrStrobe_t;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output fsrStrobe_t strobe
);
  localparam int S = SYNC_STAGES;
  localparam logic [FRAME_CNT_W-1:0] OPC_DONE  = FRAME_CNT_W'(BYTE_BITS);
  localparam logic [FRAME_CNT_W-1:0] ONE_BYTE  = FRAME_CNT_W'(2 * BYTE_BITS);
  localparam logic [FRAME_CNT_W-1:0] TWO_BYTES = FRAME_CNT_W'(3 * BYTE_BITS);

  logic [S:0]   csSh;
  logic [S:0]   sclkSh;
  logic [S-1:0] mosiSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSh   <= '1;
      sclkSh <= '0;
      mosiSh <= '0;
    end else begin
      csSh   <= {csSh[S-1:0], csN};
      sclkSh <= {sclkSh[S-1:0], sclk};
      mosiSh <= {mosiSh[S-2:0], mosi};
    end
  end

  logic csLow, csRise, sclkRise, sclkFall, mosiBit;
  assign csLow    = ~csSh[S-1];
  assign csRise   = csSh[S-1] & ~csSh[S];
  assign sclkRise = sclkSh[S-1] & ~sclkSh[S];
  assign sclkFall = ~sclkSh[S-1] & sclkSh[S];
  assign mosiBit  = mosiSh[S-1];

  logic [FRAME_CNT_W-1:0] bitCnt;
  logic [7:0] inShift, opcode, dataByte, nextByte;
  logic readMode;

  assign nextByte = {inShift[6:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      inShift  <= '0;
      opcode   <= '0;
      dataByte <= '0;
      readMode <= 1'b0;
    end else if (!csLow) begin
      bitCnt   <= '0;
      opcode   <= '0;
      readMode <= 1'b0;
    end else if (sclkRise) begin
      inShift <= nextByte;
      if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      if (bitCnt == OPC_DONE - 1'b1) begin
        opcode   <= nextByte;
        readMode <= (nextByte == OP_READ_STATUS);
      end
      if (bitCnt == ONE_BYTE - 1'b1) dataByte <= nextByte;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.setWel   = csRise && (opcode == OP_WRITE_ENABLE) && (bitCnt == OPC_DONE);
    strobe.commitWr = csRise && (opcode == OP_WRITE_STATUS) &&
                      ((bitCnt == ONE_BYTE) || (bitCnt == TWO_BYTES));
    strobe.shiftOut = readMode && sclkFall;
    strobe.outIdle  = !readMode;
    strobe.wrByte   = dataByte;
  end

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    readMode |-> !(strobe.setWel || strobe.commitWr)); // R2

  AST_FRAME_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (bitCnt == '0) && !readMode); // R4
endmodule

// File: rtl/fsr_data.sv
module fsr_data
  import fsr_pkg::*;
#(
  parameter int TW_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpN,
  input  fsrStrobe_t strobe,
  output logic       miso
);
  localparam int TW_W = $clog2(TW_CYCLES + 1);
  localparam logic [TW_W-1:0] TW_LOAD = TW_W'(TW_CYCLES - 1);

  logic [SYNC_STAGES-1:0] wpSh;
  logic       srp, wel, wip, hpm;
  logic [2:0] bp;
  logic [TW_W-1:0] busyCnt;
  logic [7:0] status, snap;
  logic [2:0] outIdx;
  logic       misoR;

  assign status = {srp, 2'b00, bp, wel, wip};
  assign hpm    = srp & ~wpSh[SYNC_STAGES-1];
  assign miso   = misoR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpSh    <= '1;
      srp     <= 1'b0;
      bp      <= '0;
      wel     <= 1'b0;
      wip     <= 1'b0;
      busyCnt <= '0;
    end else begin
      wpSh <= {wpSh[SYNC_STAGES-2:0], wpN};
      if (wip) begin
        if (busyCnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          busyCnt <= busyCnt - 1'b1;
        end
      end else if (strobe.commitWr && wel && !hpm) begin
        srp     <= strobe.wrByte[7];
        bp      <= strobe.wrByte[4:2];
        wip     <= 1'b1;
        busyCnt <= TW_LOAD;
      end else if (strobe.setWel) begin
        wel <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap   <= '0;
      outIdx <= '0;
      misoR  <= 1'b0;
    end else if (strobe.outIdle) begin
      outIdx <= '0;
      misoR  <= 1'b0;
    end else if (strobe.shiftOut) begin
      outIdx <= outIdx + 1'b1;
      if (outIdx == '0) begin
        snap  <= status;
        misoR <= status[7];
      end else begin
        misoR <= snap[3'd7 - outIdx];
      end
    end
  end

  AST_WIP_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel); // R8

  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel) && $past(strobe.commitWr)); // R5

  AST_HPM_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitWr && hpm) |=> $stable(srp) && $stable(bp) && !$rose(wip) && !$rose(wel)); // R10

  AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.commitWr || strobe.setWel) && wip) |=> $stable(srp) && $stable(bp) && !$rose(wel)); // R9

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outIdle |=> !miso); // R11
endmodule

// File: rtl/flash_status_front.sv
module flash_status_front
  import fsr_pkg::*;
#(
  parameter int TW_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  input  logic wpN,
  output logic miso
);
  fsrStrobe_t strobe;

  fsr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .strobe(strobe)
  );

  fsr_data #(.TW_CYCLES(TW_CYCLES), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .wpN(wpN), .strobe(strobe), .miso(miso)
  );
endmodule

// File: tb/flash_status_front_test.sv
`timescale 1ns/1ps
module flash_status_front_test;
  localparam int TW = 1000;
  localparam int H  = 8;
  localparam int NV = 17;

  // op[47:40] bits[39:32] data[31:16] wpN[8] expected[7:0]
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'h06, 8'd7,  16'h0000, 8'h01, 8'h00},  // R4 short count
    {8'h01, 8'd16, 16'hFF00, 8'h01, 8'h00},  // R5 no latch
    {8'h06, 8'd8,  16'h0000, 8'h01, 8'h02},  // R4
    {8'h01, 8'd15, 16'hFF00, 8'h01, 8'h02},  // R6 cancel
    {8'h01, 8'd17, 16'hFF00, 8'h01, 8'h02},  // R6 cancel
    {8'h01, 8'd16, 16'hFF00, 8'h01, 8'h9C},  // R7
    {8'h06, 8'd8,  16'h0000, 8'h01, 8'h9E},  // R4
    {8'h01, 8'd24, 16'h00FF, 8'h01, 8'h00},  // R6 two bytes
    {8'h06, 8'd8,  16'h0000, 8'h01, 8'h02},  // R4
    {8'h01, 8'd16, 16'h8800, 8'h01, 8'h88},  // R7
    {8'h5A, 8'd8,  16'h0000, 8'h01, 8'h88},  // R11
    {8'h5A, 8'd16, 16'hFFFF, 8'h01, 8'h88},  // R11
    {8'h06, 8'd8,  16'h0000, 8'h00, 8'h8A},  // R4
    {8'h01, 8'd16, 16'h0000, 8'h00, 8'h8A},  // R10 protected
    {8'h01, 8'd16, 16'h0000, 8'h01, 8'h00},  // R10 pin high
    {8'h06, 8'd8,  16'h0000, 8'h00, 8'h02},  // R4
    {8'h01, 8'd16, 16'h1C00, 8'h00, 8'h1C}   // R10 bit 7 clear
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0, wpN = 1'b1;
  logic miso;
  logic [7:0] rd [0:3];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_status_front #(.TW_CYCLES(TW)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN), .miso(miso)
  );

  function automatic string vecReq(int i);
    case (i)
      1:             return "R5";
      3, 4, 7:       return "R6";
      5, 9:          return "R7";
      10, 11:        return "R11";
      13, 14, 16:    return "R10";
      default:       return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBits(input logic [7:0] op, input int nBits, input logic [15:0] data,
                           output bit sawHigh);
    sawHigh = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      mosi = (i < 8) ? op[7-i] : data[15-(i-8)];
      waitN(H);
      if (miso) sawHigh = 1'b1;
      sclk = 1'b1;
      waitN(H);
      sclk = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [7:0] op, input int nBits, input logic [15:0] data,
                           output bit sawHigh);
    csN = 1'b0;
    waitN(H);
    clockBits(op, nBits, data, sawHigh);
    waitN(H);
    csN = 1'b1;
    waitN(2 * H);
  endtask

  task automatic readBytes(input int nBytes);
    for (int b = 0; b < nBytes; b++) begin
      for (int j = 0; j < 8; j++) begin
        waitN(H);
        rd[b][7-j] = miso;
        sclk = 1'b1;
        waitN(H);
        sclk = 1'b0;
      end
    end
  endtask

  task automatic readStatus(input int nBytes);
    bit dummy;
    csN = 1'b0;
    waitN(H);
    clockBits(8'h05, 8, 16'h0000, dummy);
    readBytes(nBytes);
    waitN(H);
    csN = 1'b1;
    waitN(2 * H);
  endtask

  // write, then release the first read bit exactly k clocks after chip select rose
  task automatic writeAndTimedRead(input logic [7:0] data, input int k, input int nBytes);
    bit dummy;
    sendFrame(8'h06, 8, 16'h0000, dummy);
    csN = 1'b0;
    waitN(H);
    clockBits(8'h01, 16, {data, 8'h00}, dummy);
    waitN(H);
    csN = 1'b1;
    waitN(4);
    csN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      mosi = 1'(8'h05 >> (7 - i));
      waitN(H);
      sclk = 1'b1;
      waitN(H);
      if (i < 7) sclk = 1'b0;
    end
    waitN(k - 4 - 16 * H);
    sclk = 1'b0;
    readBytes(nBytes);
    waitN(H);
    csN = 1'b1;
    waitN(2 * H);
  endtask

  initial begin
    bit sawHigh;
    waitN(5);
    rstN = 1'b1;
    waitN(5);
    check("R1 miso", {7'b0, miso}, 8'h00);
    readStatus(1);
    check("R1 status", rd[0], 8'h00);

    for (int v = 0; v < NV; v++) begin
      wpN = VEC[v][8];
      waitN(8);
      sendFrame(VEC[v][47:40], int'(VEC[v][39:32]), VEC[v][31:16], sawHigh);
      check("R11 miso low", {7'b0, sawHigh}, 8'h00);
      waitN(TW + 20);
      readStatus(1);
      check(vecReq(v), rd[0], VEC[v][7:0]);
    end

    // busy phase: visible at once, repeating, blocking further writes
    wpN = 1'b1;
    waitN(8);
    sendFrame(8'h06, 8, 16'h0000, sawHigh);
    sendFrame(8'h01, 16, 16'h8000, sawHigh);
    readStatus(3);
    check("R8 busy byte", rd[0], 8'h83);
    check("R3 repeat 2", rd[1], 8'h83);
    check("R3 repeat 3", rd[2], 8'h83);
    sendFrame(8'h01, 16, 16'h9C00, sawHigh);
    waitN(TW + 20);
    readStatus(1);
    check("R9 write while busy", rd[0], 8'h80);

    // expiry and snapshot in the same cycle
    writeAndTimedRead(8'h04, TW, 2);
    check("R8 last busy cycle", rd[0], 8'h07);
    check("R3 next byte cleared", rd[1], 8'h04);
    waitN(TW);
    writeAndTimedRead(8'h08, TW + 1, 1);
    check("R8 first idle cycle", rd[0], 8'h08);
    check("R2 miso idle after read", {7'b0, miso}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule